// File: doc/BRIEF.md
# ALU Status Flag Unit

This block sits beside an integer adder/subtractor and turns each result into a set of condition bits held in a status register. Each cycle it receives the two operands, the result and the adder's top-level carry (or borrow) out, together with the operation kind and an operand width of byte, word or doubleword. When the update strobe is high, the register takes new carry, overflow, sign, zero, nibble-carry and parity bits. A direction control bit lives in the same register. It has its own write strobe and ignores the update strobe.

The carry into any narrow width comes from the operand and result bits at that width's top, so the adder only has to supply the carry out of the full datapath. Sign and overflow are taken from the top bit of the selected width. Zero looks only at the bits of that width. Parity always covers the low byte.

Top module: `alu_flag_unit`

## Requirements
- R1: `flags_o` bits are ordered carry=0, parity=1, aux=2, zero=3, sign=4, overflow=5, direction=6. All seven bits are 0 after reset.
- R2: With update high and op_i of 0 (add) or 1 (subtract), carry is set in the next cycle when the unsigned add at the selected width exceeds its range, or when the unsigned subtract borrows. width_i is 0 for 8 bits, 1 for 16 bits, and 2 or 3 for the full DW bits. At full width the carry equals cout_i.
- R3: For add, overflow is set when both operands have the same sign and the result's sign differs from them. For subtract, it is set when the operand signs differ and the result's sign differs from the first operand's. The sign is the top bit of the selected width.
- R4: On any update, sign takes the top bit of the result at the selected width.
- R5: On any update, zero is set exactly when every result bit inside the selected width is 0. Bits above the width are ignored.
- R6: On an add or subtract update, aux is set on a carry or borrow out of bit 3 into bit 4.
- R7: On any update, parity is set when res_i[7:0] holds an even number of ones, whatever the width.
- R8: When op_i is 2 or 3 (logic), an update clears carry and overflow and leaves aux at its previous value.
- R9: With update low and the direction strobe low, `flags_o` does not change.
- R10: When dir_we_i is high, direction takes dir_i in the next cycle, whatever update is. The direction bit changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Load the six condition flags |
| op_i | input | 2 | 0 add, 1 subtract, 2 or 3 logic |
| width_i | input | 2 | 0 byte, 1 word, 2 or 3 doubleword |
| a_i | input | DW | First operand |
| b_i | input | DW | Second operand |
| res_i | input | DW | Result from the adder or logic unit |
| cout_i | input | 1 | Carry or borrow out of the full datapath |
| dir_we_i | input | 1 | Direction bit write strobe |
| dir_i | input | 1 | Direction value to write |
| flags_o | output | 7 | Status register |

## Verification
Every byte add pair is applied, so each pairing of the unsigned carry, the signed overflow and the nibble carry boundaries occurs. A dense byte subtract grid does the same for borrows. Word and doubleword vectors use random operands whose upper bits are not zero. This shows that sign, zero and overflow follow the selected width and not bit 31, and that a narrow carry is not taken from cout_i. Fixed signed and unsigned wrap corners are added to these vectors. Logic operations run after both set and cleared aux states, which shows that aux is kept and not cleared. Hold and direction-strobe phases show that the two write paths are independent.

// File: rtl/afu_pkg.sv
package afu_pkg;
  localparam int unsigned FLAG_CARRY  = 0;
  localparam int unsigned FLAG_PARITY = 1;
  localparam int unsigned FLAG_AUX    = 2;
  localparam int unsigned FLAG_ZERO   = 3;
  localparam int unsigned FLAG_SIGN   = 4;
  localparam int unsigned FLAG_OVER   = 5;
  localparam int unsigned FLAG_DIR    = 6;
  localparam int unsigned NUM_FLAGS   = 7;

  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_SUB   = 2'd1,
    OP_LOG   = 2'd2,
    OP_LOG_X = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    WD_BYTE   = 2'd0,
    WD_WORD   = 2'd1,
    WD_FULL   = 2'd2,
    WD_FULL_X = 2'd3
  } width_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } cond_t;
endpackage

// File: rtl/afu_lane_sel.sv
module afu_lane_sel #(
  parameter int unsigned DW = 32
) (
  input  logic [1:0]    width_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] res_i,
  input  logic          cout_i,
  output logic          a_top_o,
  output logic          b_top_o,
  output logic          r_top_o,
  output logic          lane_cry_o,
  output logic          zero_o
);
  import afu_pkg::*;
  localparam int unsigned BYTE_W = DW / 4;
  localparam int unsigned WORD_W = DW / 2;
  localparam logic [DW-1:0] BYTE_MASK = {{(DW-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  localparam logic [DW-1:0] WORD_MASK = {{(DW-WORD_W){1'b0}}, {WORD_W{1'b1}}};

  // carry into bit k of a sum/difference: a[k]^b[k]^r[k]
  logic byte_cry, word_cry;
  assign byte_cry = a_i[BYTE_W] ^ b_i[BYTE_W] ^ res_i[BYTE_W];
  assign word_cry = a_i[WORD_W] ^ b_i[WORD_W] ^ res_i[WORD_W];

  always_comb begin
    unique case (width_e'(width_i))
      WD_BYTE: begin
        a_top_o    = a_i[BYTE_W-1];
        b_top_o    = b_i[BYTE_W-1];
        r_top_o    = res_i[BYTE_W-1];
        lane_cry_o = byte_cry;
        zero_o     = ~|(res_i & BYTE_MASK);
      end
      WD_WORD: begin
        a_top_o    = a_i[WORD_W-1];
        b_top_o    = b_i[WORD_W-1];
        r_top_o    = res_i[WORD_W-1];
        lane_cry_o = word_cry;
        zero_o     = ~|(res_i & WORD_MASK);
      end
      default: begin
        a_top_o    = a_i[DW-1];
        b_top_o    = b_i[DW-1];
        r_top_o    = res_i[DW-1];
        lane_cry_o = cout_i;
        zero_o     = ~|res_i;
      end
    endcase
  end
endmodule

// File: rtl/afu_arith_flags.sv
module afu_arith_flags (
  input  logic [1:0] op_i,
  input  logic       a_top_i,
  input  logic       b_top_i,
  input  logic       r_top_i,
  input  logic       lane_cry_i,
  input  logic       a_nib_i,
  input  logic       b_nib_i,
  input  logic       r_nib_i,
  output logic       arith_o,
  output logic       cry_o,
  output logic       ovf_o,
  output logic       aux_o
);
  import afu_pkg::*;
  logic sign_flip;
  assign sign_flip = r_top_i ^ a_top_i;
  assign aux_o     = a_nib_i ^ b_nib_i ^ r_nib_i;

  always_comb begin
    unique case (op_e'(op_i))
      OP_ADD: begin
        arith_o = 1'b1;
        cry_o   = lane_cry_i;
        ovf_o   = ~(a_top_i ^ b_top_i) & sign_flip;
      end
      OP_SUB: begin
        arith_o = 1'b1;
        cry_o   = lane_cry_i;
        ovf_o   = (a_top_i ^ b_top_i) & sign_flip;
      end
      default: begin
        arith_o = 1'b0;
        cry_o   = 1'b0;
        ovf_o   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/afu_flag_reg.sv
module afu_flag_reg
  import afu_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_i,
  input  logic                 arith_i,
  input  cond_t                cond_i,
  input  logic                 dir_we_i,
  input  logic                 dir_i,
  output logic [NUM_FLAGS-1:0] flags_o
);
  cond_t cond_q;
  logic  dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= '0;
    end else if (upd_i) begin
      cond_q.cry <= cond_i.cry;
      cond_q.par <= cond_i.par;
      cond_q.zro <= cond_i.zro;
      cond_q.sgn <= cond_i.sgn;
      cond_q.ovf <= cond_i.ovf;
      if (arith_i) cond_q.aux <= cond_i.aux;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dir_q <= 1'b0;
    else if (dir_we_i) dir_q <= dir_i;
  end

  always_comb begin
    flags_o              = '0;
    flags_o[FLAG_CARRY]  = cond_q.cry;
    flags_o[FLAG_PARITY] = cond_q.par;
    flags_o[FLAG_AUX]    = cond_q.aux;
    flags_o[FLAG_ZERO]   = cond_q.zro;
    flags_o[FLAG_SIGN]   = cond_q.sgn;
    flags_o[FLAG_OVER]   = cond_q.ovf;
    flags_o[FLAG_DIR]    = dir_q;
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import afu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_i,
  input  logic [1:0]           op_i,
  input  logic [1:0]           width_i,
  input  logic [DW-1:0]        a_i,
  input  logic [DW-1:0]        b_i,
  input  logic [DW-1:0]        res_i,
  input  logic                 cout_i,
  input  logic                 dir_we_i,
  input  logic                 dir_i,
  output logic [NUM_FLAGS-1:0] flags_o
);
  localparam int unsigned NIB = 4;
  localparam int unsigned PAR_W = 8;

  logic a_top, b_top, r_top, lane_cry, zero;
  logic arith, cry, ovf, aux;
  cond_t cond;

  afu_lane_sel #(.DW(DW)) u_lane (
    .width_i   (width_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .res_i     (res_i),
    .cout_i    (cout_i),
    .a_top_o   (a_top),
    .b_top_o   (b_top),
    .r_top_o   (r_top),
    .lane_cry_o(lane_cry),
    .zero_o    (zero)
  );

  afu_arith_flags u_arith (
    .op_i      (op_i),
    .a_top_i   (a_top),
    .b_top_i   (b_top),
    .r_top_i   (r_top),
    .lane_cry_i(lane_cry),
    .a_nib_i   (a_i[NIB]),
    .b_nib_i   (b_i[NIB]),
    .r_nib_i   (res_i[NIB]),
    .arith_o   (arith),
    .cry_o     (cry),
    .ovf_o     (ovf),
    .aux_o     (aux)
  );

  always_comb begin
    cond.cry = cry;
    cond.par = ~^res_i[PAR_W-1:0];
    cond.aux = aux;
    cond.zro = zero;
    cond.sgn = r_top;
    cond.ovf = ovf;
  end

  afu_flag_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (upd_i),
    .arith_i (arith),
    .cond_i  (cond),
    .dir_we_i(dir_we_i),
    .dir_i   (dir_i),
    .flags_o (flags_o)
  );
endmodule

// File: rtl/afu_flag_checker.sv
module afu_flag_checker
  import afu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 upd_i,
  input logic [1:0]           op_i,
  input logic [DW-1:0]        res_i,
  input logic                 dir_we_i,
  input logic                 dir_i,
  input logic [NUM_FLAGS-1:0] flags_o
);
  logic is_log;
  assign is_log = op_i[1];

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !dir_we_i) |=> $stable(flags_o)); // R9
  AST_LOGIC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && is_log) |=> (!flags_o[FLAG_CARRY] && !flags_o[FLAG_OVER])); // R8
  AST_LOGIC_KEEPS_AUX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && is_log) |=> (flags_o[FLAG_AUX] == $past(flags_o[FLAG_AUX]))); // R8
  AST_ZERO_ON_NULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && res_i == '0) |=> (flags_o[FLAG_ZERO] && !flags_o[FLAG_SIGN])); // R5
  AST_SIGN_EXCL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> !(flags_o[FLAG_ZERO] && flags_o[FLAG_SIGN])); // R4
  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i |=> (flags_o[FLAG_DIR] == $past(dir_i))); // R10
  AST_DIR_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_we_i |=> $stable(flags_o[FLAG_DIR])); // R10
  AST_PAR_NULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && res_i[7:0] == 8'h00) |=> flags_o[FLAG_PARITY]); // R7
endmodule

bind alu_flag_unit afu_flag_checker #(.DW(DW)) u_chk (.*);

// File: tb/alu_flag_unit_test.sv
module alu_flag_unit_test;
  localparam int unsigned DW = 32;
  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          upd_i = 1'b0;
  logic [1:0]    op_i = 2'd0;
  logic [1:0]    width_i = 2'd0;
  logic [DW-1:0] a_i = '0, b_i = '0, res_i = '0;
  logic          cout_i = 1'b0, dir_we_i = 1'b0, dir_i = 1'b0;
  logic [6:0]    flags_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic exp_aux = 1'b0;
  logic exp_dir = 1'b0;

  alu_flag_unit #(.DW(DW)) uut (.*);

  always #4 clk_i = ~clk_i;

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b (op %0d w %0d a %h b %h r %h)",
               req, got, exp, op_i, width_i, a_i, b_i, res_i);
    end
  endtask

  // expected {ovf,sgn,zro,aux,par,cry}
  function automatic logic [5:0] model(input logic [1:0] op, input logic [1:0] wd,
      input logic [31:0] a, input logic [31:0] b, input logic [31:0] r, input logic aux_prev);
    int w;
    longint unsigned m, ua, ub, ur;
    longint sa, sb, sv, half;
    logic c, o, x, s, z, p;
    w = (wd == 2'd0) ? 8 : (wd == 2'd1) ? 16 : 32;
    m = (64'd1 << w) - 1;
    half = longint'(64'd1 << (w - 1));
    ua = {32'd0, a} & m; ub = {32'd0, b} & m; ur = {32'd0, r} & m;
    sa = (ua >= 64'(half)) ? longint'(ua) - 2 * half : longint'(ua);
    sb = (ub >= 64'(half)) ? longint'(ub) - 2 * half : longint'(ub);
    if (op == 2'd0) begin
      c = (ua + ub) > m;
      sv = sa + sb;
      x = ({28'd0, a[3:0]} + {28'd0, b[3:0]}) > 32'd15;
    end else if (op == 2'd1) begin
      c = ua < ub;
      sv = sa - sb;
      x = a[3:0] < b[3:0];
    end else begin
      c = 1'b0; sv = 0; x = aux_prev;
    end
    o = (op[1] == 1'b0) && (sv > half - 1 || sv < -half);
    s = ur[w-1];
    z = (ur == 0);
    p = ($countones(r[7:0]) % 2) == 0;
    return {o, s, z, x, p, c};
  endfunction

  // drive at a negedge, check at the following negedge
  task automatic run_vec(input logic [1:0] op, input logic [1:0] wd,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] r);
    logic [5:0] e;
    logic [32:0] full;
    upd_i = 1'b1; op_i = op; width_i = wd; a_i = a; b_i = b; res_i = r;
    if (op == 2'd0) begin
      full = {1'b0, a} + {1'b0, b};
      cout_i = full[32];
    end else begin
      cout_i = (op == 2'd1) && (a < b);
    end
    e = model(op, wd, a, b, r, exp_aux);
    @(negedge clk_i);
    upd_i = 1'b0;
    chk(flags_o[0], e[0], "R2 carry");
    chk(flags_o[1], e[1], "R7 parity");
    chk(flags_o[2], e[2], op[1] ? "R8 aux kept" : "R6 aux");
    chk(flags_o[3], e[3], "R5 zero");
    chk(flags_o[4], e[4], "R4 sign");
    chk(flags_o[5], e[5], op[1] ? "R8 overflow cleared" : "R3 overflow");
    chk(flags_o[6], exp_dir, "R10 direction untouched");
    exp_aux = e[2];
  endtask

  task automatic arith_vec(input logic [1:0] op, input logic [1:0] wd,
                           input logic [31:0] a, input logic [31:0] b);
    run_vec(op, wd, a, b, (op == 2'd0) ? a + b : a - b);
  endtask

  initial begin
    logic [6:0] snap;
    #20;
    chk(flags_o == 7'd0 ? 1'b1 : 1'b0, 1'b1, "R1 reset state");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(flags_o == 7'd0 ? 1'b1 : 1'b0, 1'b1, "R1 after reset release");

    // byte add, every pair
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        arith_vec(2'd0, 2'd0, 32'(a), 32'(b));
    // byte subtract, dense grid
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 7)
        arith_vec(2'd1, 2'd0, 32'(a), 32'(b));
    arith_vec(2'd1, 2'd0, 32'h80, 32'h01);
    arith_vec(2'd1, 2'd0, 32'h7f, 32'hff);
    // word and full widths with garbage upper bits
    for (int i = 0; i < 3000; i++) begin
      arith_vec(2'(i & 1), 2'd1, $urandom, $urandom);
      arith_vec(2'(i & 1), 2'd2, $urandom, $urandom);
    end
    for (int i = 0; i < 200; i++)
      arith_vec(2'(i & 1), 2'd3, $urandom, $urandom);
    // signed and unsigned wrap corners
    arith_vec(2'd0, 2'd1, 32'hABCD_7FFF, 32'h0000_0001);
    arith_vec(2'd0, 2'd1, 32'h1234_FFFF, 32'h0000_0001);
    arith_vec(2'd1, 2'd1, 32'h0000_8000, 32'h0000_0001);
    arith_vec(2'd0, 2'd2, 32'h7FFF_FFFF, 32'h0000_0001);
    arith_vec(2'd0, 2'd2, 32'hFFFF_FFFF, 32'h0000_0001);
    arith_vec(2'd1, 2'd2, 32'h8000_0000, 32'h0000_0001);
    arith_vec(2'd1, 2'd3, 32'h0000_0000, 32'h0000_0001);
    arith_vec(2'd0, 2'd0, 32'hFFFF_FF00, 32'h0000_0000);

    // logic ops after aux set, then after aux cleared
    arith_vec(2'd0, 2'd0, 32'h0F, 32'h01);
    for (int i = 0; i < 250; i++)
      run_vec(2'd2 + 2'(i & 1), 2'(i % 3), $urandom, $urandom, $urandom);
    arith_vec(2'd0, 2'd0, 32'h10, 32'h10);
    for (int i = 0; i < 250; i++)
      run_vec(2'd2 + 2'(i & 1), 2'(i % 3), $urandom, $urandom, $urandom);
    run_vec(2'd2, 2'd2, 32'd0, 32'd0, 32'd0);
    arith_vec(2'd0, 2'd0, 32'h0F, 32'h01);
    run_vec(2'd3, 2'd0, 32'd0, 32'd0, 32'h0000_0080);

    // hold with update low
    arith_vec(2'd0, 2'd0, 32'hFF, 32'h81);
    snap = flags_o;
    for (int i = 0; i < 20; i++) begin
      op_i = 2'(i); width_i = 2'(i >> 2);
      a_i = $urandom; b_i = $urandom; res_i = $urandom; cout_i = ~cout_i;
      @(negedge clk_i);
      chk(flags_o == snap ? 1'b1 : 1'b0, 1'b1, "R9 hold");
    end

    // direction strobe alone, then together with update
    dir_we_i = 1'b1; dir_i = 1'b1;
    @(negedge clk_i);
    dir_we_i = 1'b0; dir_i = 1'b0; exp_dir = 1'b1;
    chk(flags_o[6], 1'b1, "R10 direction set");
    chk(flags_o[5:0] == snap[5:0] ? 1'b1 : 1'b0, 1'b1, "R10 other flags kept");
    arith_vec(2'd1, 2'd0, 32'h00, 32'h01);
    dir_we_i = 1'b1; dir_i = 1'b0; exp_dir = 1'b0;
    arith_vec(2'd0, 2'd1, 32'h0000_4000, 32'h0000_4000);
    dir_we_i = 1'b0;
    dir_i = 1'b1;
    @(negedge clk_i);
    chk(flags_o[6], 1'b0, "R10 dir_i ignored without strobe");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule